// File: doc/BRIEF.md
# Coalescing Interrupt Cause Controller

This block gathers interrupt causes from internal sources into a 32-bit status word and presents that word, an enable mask, an 8-bit coalescing delay and an 8-bit periodic interval to a host over a plain register strobe interface. It drives one level-sensitive interrupt line. When the first enabled cause appears, the block does not interrupt at once. It opens a coalescing window and lets further causes pile up in the status word, so the host takes one interrupt for a burst of events instead of one for each event.

Time is measured in units of 32 microseconds. A prescaler built from the clocks-per-microsecond parameter produces one tick per unit. One designated high-priority receive input ends the window early. A periodic generator raises the receive-periodic cause at a programmable number of units. The host acknowledges causes by writing ones to the status word.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: The status word (register index 0) resets to zero. A hardware cause sets its bit at the next clock edge. A host write clears exactly the bits written as 1 and leaves bits written as 0 unchanged. A status bit never falls unless a status write clears it.
- R2: The enable mask (index 1, 32 bits, reset 0) gates the interrupt. When no status bit is both set and enabled, the interrupt output is low in the following cycle.
- R3: The coalescing register (index 2) holds 8 bits, reads back with zero upper bits and resets to 0x40. One unit is CLKS_PER_US*US_PER_UNIT clock cycles. When an enabled cause is pending while the block is idle, a window of N units starts, where N is the register value. The window closes on the N-th unit tick after it starts.
- R4: If a hardware set and a host clear hit the same status bit in the same cycle, the bit ends set.
- R5: The high-priority receive input sets status bit 31. If mask bit 31 is enabled, it also closes the window at the same edge, and the interrupt rises on the following edge whatever the coalescing value. With mask bit 31 disabled, the bit is recorded but no interrupt follows.
- R6: The interrupt is a registered level. It is high in the cycle after the window is closed while an enabled status bit is set. It stays high until no enabled bit is set, and falls one edge after that. A new window starts for the next cause.
- R7: The periodic register (index 3) holds 8 bits and resets to 0. A value of 0 disables the generator. A value P sets status bit 28 on every P-th unit tick. Writing the register restarts the count.
- R8: A coalescing value of 0 closes the window in the cycle after the pending state is seen. The interrupt therefore rises two edges after the edge that captured the cause.
- R9: Register indices other than 0 to 3 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_cause_i | input | 32 | Per-bit cause set pulses from internal sources |
| hipri_rx_i | input | 1 | High-priority receive event, bypasses the window |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with CLKS_PER_US=2 and US_PER_UNIT=2, so one unit is four clock cycles. With that setting even the widest coalescing window (255 units, about a thousand cycles) and several periodic intervals fit in a short run, and the exact edge on which the window closes can be checked with real register values instead of a shortened counter. A behavioural model tracks status, window and periodic count on every clock and is compared with the interrupt line in every cycle. Directed reads cover same-cycle set and clear, the bypass, zero coalescing and the disabled periodic generator.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int CAUSE_W        = 32;
  localparam int TIMER_W        = 8;
  localparam int POS_RX_HIPRI   = 31;  // receive DMA cause, fed by the bypass input
  localparam int POS_RX_PERIOD  = 28;  // receive-periodic cause

  localparam int IDX_STATUS = 0;
  localparam int IDX_MASK   = 1;
  localparam int IDX_COAL   = 2;
  localparam int IDX_PERIOD = 3;

  typedef enum logic [1:0] {
    WIN_IDLE    = 2'd0,
    WIN_RUN     = 2'd1,
    WIN_EXPIRED = 2'd2
  } win_state_e;

  // write-one-to-clear with set taking precedence
  function automatic logic [CAUSE_W-1:0] w1c_next(
    input logic [CAUSE_W-1:0] cur,
    input logic [CAUSE_W-1:0] clr,
    input logic [CAUSE_W-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_enabled(
    input logic [CAUSE_W-1:0] stat,
    input logic [CAUSE_W-1:0] msk
  );
    return |(stat & msk);
  endfunction

endpackage

// File: rtl/icc_unit_tick.sv
module icc_unit_tick #(
  parameter int CLKS_PER_US = 125,
  parameter int US_PER_UNIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic unit_tick
);
  localparam int UNIT_CYC = CLKS_PER_US * US_PER_UNIT;
  localparam int CNT_W    = $clog2(UNIT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign unit_tick = (cnt_q == CNT_W'(UNIT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (unit_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/icc_cause_reg.sv
module icc_cause_reg
  import icc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_vec,
  input  logic [CAUSE_W-1:0] clr_vec,
  output logic [CAUSE_W-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= w1c_next(status_q, clr_vec, set_vec);
  end
endmodule

// File: rtl/icc_periodic.sv
module icc_periodic
  import icc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unit_tick,
  input  logic [TIMER_W-1:0] period_q,
  input  logic               restart,
  output logic               fire
);
  logic [TIMER_W-1:0] pcnt_q;
  logic               active;

  assign active = (period_q != '0);
  assign fire   = unit_tick & active & (pcnt_q >= period_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pcnt_q <= '0;
    else if (restart || !active) pcnt_q <= '0;
    else if (unit_tick)          pcnt_q <= fire ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/icc_window.sv
module icc_window
  import icc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unit_tick,
  input  logic               pending,
  input  logic               bypass,
  input  logic [TIMER_W-1:0] coal_q,
  output win_state_e         state_q,
  output logic               irq_q
);
  win_state_e         state_d;
  logic [TIMER_W-1:0] rem_q, rem_d;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    unique case (state_q)
      WIN_IDLE: if (pending) begin
        if (coal_q == '0) state_d = WIN_EXPIRED;
        else begin
          state_d = WIN_RUN;
          rem_d   = coal_q;
        end
      end
      WIN_RUN: begin
        if (!pending) state_d = WIN_IDLE;
        else if (unit_tick) begin
          if (rem_q == TIMER_W'(1)) state_d = WIN_EXPIRED;
          else                      rem_d   = rem_q - 1'b1;
        end
      end
      WIN_EXPIRED: if (!pending) state_d = WIN_IDLE;
      default: state_d = WIN_IDLE;
    endcase
    if (bypass) state_d = WIN_EXPIRED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      rem_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      irq_q   <= (state_q == WIN_EXPIRED) && pending;
    end
  end
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import icc_pkg::*;
#(
  parameter int CLKS_PER_US = 125,
  parameter int US_PER_UNIT = 32,
  parameter int ADDR_W      = 4,
  parameter logic [TIMER_W-1:0] COAL_RESET = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] hw_cause_i,
  input  logic               hipri_rx_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [CAUSE_W-1:0] reg_wdata_i,
  output logic [CAUSE_W-1:0] reg_rdata_o,
  output logic               irq_o
);
  // named internal events, also observed by the checker
  logic               stat_wr, mask_wr, coal_wr, per_wr;
  logic               unit_tick, per_fire, pending, bypass;
  logic [CAUSE_W-1:0] set_vec, clr_vec, status_q, mask_q;
  logic [TIMER_W-1:0] coal_q, per_q;
  win_state_e         win_state;

  assign stat_wr = reg_wr_i && (reg_addr_i == ADDR_W'(IDX_STATUS));
  assign mask_wr = reg_wr_i && (reg_addr_i == ADDR_W'(IDX_MASK));
  assign coal_wr = reg_wr_i && (reg_addr_i == ADDR_W'(IDX_COAL));
  assign per_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(IDX_PERIOD));

  always_comb begin
    set_vec = hw_cause_i;
    set_vec[POS_RX_HIPRI]  = set_vec[POS_RX_HIPRI]  | hipri_rx_i;
    set_vec[POS_RX_PERIOD] = set_vec[POS_RX_PERIOD] | per_fire;
  end
  assign clr_vec = stat_wr ? reg_wdata_i : '0;
  assign pending = any_enabled(status_q, mask_q);
  assign bypass  = hipri_rx_i & mask_q[POS_RX_HIPRI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      coal_q <= COAL_RESET;
      per_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= reg_wdata_i;
      if (coal_wr) coal_q <= reg_wdata_i[TIMER_W-1:0];
      if (per_wr)  per_q  <= reg_wdata_i[TIMER_W-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_W'(IDX_STATUS): reg_rdata_o = status_q;
      ADDR_W'(IDX_MASK):   reg_rdata_o = mask_q;
      ADDR_W'(IDX_COAL):   reg_rdata_o = {{(CAUSE_W-TIMER_W){1'b0}}, coal_q};
      ADDR_W'(IDX_PERIOD): reg_rdata_o = {{(CAUSE_W-TIMER_W){1'b0}}, per_q};
      default:             reg_rdata_o = '0;
    endcase
  end

  icc_unit_tick #(
    .CLKS_PER_US(CLKS_PER_US),
    .US_PER_UNIT(US_PER_UNIT)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_tick(unit_tick)
  );

  icc_cause_reg u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .status_q(status_q)
  );

  icc_periodic u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_tick(unit_tick),
    .period_q (per_q),
    .restart  (per_wr),
    .fire     (per_fire)
  );

  icc_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_tick(unit_tick),
    .pending  (pending),
    .bypass   (bypass),
    .coal_q   (coal_q),
    .state_q  (win_state),
    .irq_q    (irq_o)
  );
endmodule

// File: rtl/icc_checker.sv
module icc_checker
  import icc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               stat_wr,
  input logic               hipri_rx_i,
  input logic               pending,
  input logic [CAUSE_W-1:0] set_vec,
  input logic [CAUSE_W-1:0] status_q,
  input logic [CAUSE_W-1:0] mask_q,
  input logic [TIMER_W-1:0] coal_q,
  input win_state_e         win_state,
  input logic               irq_o
);
  // R1: a status bit falls only through a host status write
  a_r1_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4: every set request is visible next cycle, even against a clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R5: enabled high-priority event closes the window at once
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (hipri_rx_i && mask_q[POS_RX_HIPRI]) |=> (win_state == WIN_EXPIRED));

  // R2: nothing enabled pending means the line is low next cycle
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq_o);

  // R6: the line rises only from a closed window with pending causes
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(win_state) == WIN_EXPIRED));

  // R8: zero coalescing closes the window on the next edge
  a_r8_zero_window: assert property (@(posedge clk) disable iff (!rst_n)
    (win_state == WIN_IDLE && pending && coal_q == '0) |=> (win_state == WIN_EXPIRED));
endmodule

bind irq_coalesce_ctrl icc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_wr   (stat_wr),
  .hipri_rx_i(hipri_rx_i),
  .pending   (pending),
  .set_vec   (set_vec),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .coal_q    (coal_q),
  .win_state (win_state),
  .irq_o     (irq_o)
);

// File: tb/irq_coalesce_ctrl_tb.sv
`timescale 1ns/1ps
module irq_coalesce_ctrl_tb;
  localparam int CPU  = 2;
  localparam int UPU  = 2;
  localparam int UNIT = CPU * UPU;
  localparam int AW   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_cause = '0;
  logic        hipri = 1'b0;
  logic        wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_coalesce_ctrl #(.CLKS_PER_US(CPU), .US_PER_UNIT(UPU), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_cause_i(hw_cause), .hipri_rx_i(hipri),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- behavioural reference ----------------
  int unsigned m_stat, m_mask, m_coal, m_per, m_tick, m_pcnt, m_rem;
  int          m_win;   // 0 idle, 1 counting, 2 closed
  bit          m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 0; m_mask <= 0; m_coal <= 'h40; m_per <= 0;
      m_tick <= 0; m_pcnt <= 0; m_rem <= 0; m_win <= 0; m_irq <= 0;
    end else begin : step
      bit tk, fire, pend;
      int unsigned setv, clrv, nwin, nrem;
      tk   = (m_tick == UNIT - 1);
      fire = tk && (m_per != 0) && (m_pcnt + 1 >= m_per);
      pend = (m_stat & m_mask) != 0;
      setv = hw_cause | (hipri ? 32'h8000_0000 : 0) | (fire ? 32'h1000_0000 : 0);
      clrv = (wr && addr == 0) ? wdata : 0;
      nwin = m_win; nrem = m_rem;
      if (m_win == 0) begin
        if (pend) begin
          if (m_coal == 0) nwin = 2; else begin nwin = 1; nrem = m_coal; end
        end
      end else if (m_win == 1) begin
        if (!pend) nwin = 0;
        else if (tk) begin
          if (m_rem == 1) nwin = 2; else nrem = m_rem - 1;
        end
      end else if (!pend) nwin = 0;
      if (hipri && m_mask[31]) nwin = 2;
      m_irq  <= (m_win == 2) && pend;
      m_win  <= nwin;
      m_rem  <= nrem;
      m_tick <= tk ? 0 : m_tick + 1;
      if ((wr && addr == 3) || m_per == 0) m_pcnt <= 0;
      else if (tk) m_pcnt <= fire ? 0 : m_pcnt + 1;
      m_stat <= (m_stat & ~clrv) | setv;
      if (wr && addr == 1) m_mask <= wdata;
      if (wr && addr == 2) m_coal <= wdata & 'hff;
      if (wr && addr == 3) m_per  <= wdata & 'hff;
    end
  end

  // R6: interrupt line compared with the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R6 per-cycle irq at %0t: actual=%0b expected=%0b", $time, irq, m_irq);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse_cause(input logic [31:0] c);
    hw_cause = c;
    @(negedge clk);
    hw_cause = '0;
  endtask

  task automatic pulse_hipri();
    hipri = 1'b1;
    @(negedge clk);
    hipri = 1'b0;
  endtask

  task automatic check_rd(input int a, input logic [31:0] exp, input string req);
    addr = AW'(a);
    #1;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s read idx %0d: actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic check_irq(input bit exp, input string req);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq: actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 R3 R7 R9 reset values
    check_rd(0, 32'h0, "R1");
    check_rd(1, 32'h0, "R2");
    check_rd(2, 32'h40, "R3");
    check_rd(3, 32'h0, "R7");
    check_irq(1'b0, "R1");

    // R2: cause with empty mask is recorded, no interrupt
    pulse_cause(32'h1);
    idle(10);
    check_rd(0, 32'h1, "R2");
    check_irq(1'b0, "R2");

    // R1: zero write keeps, one write clears
    reg_write(0, 32'h0);
    check_rd(0, 32'h1, "R1");
    reg_write(0, 32'h1);
    check_rd(0, 32'h0, "R1");

    // R9: unmapped index
    reg_write(5, 32'hffff_ffff);
    check_rd(5, 32'h0, "R9");
    check_rd(1, 32'h0, "R9");

    // R3: 8-bit coalescing register and a 3-unit window
    reg_write(2, 32'hffff_ff03);
    check_rd(2, 32'h03, "R3");
    reg_write(1, 32'hffff_ffff);
    pulse_cause(32'h8);
    idle(2);
    check_irq(1'b0, "R3");
    pulse_cause(32'h40);
    idle(3 * UNIT + 4);
    check_irq(1'b1, "R3");
    check_rd(0, 32'h48, "R6");

    // R6: level holds, drops after acknowledge
    idle(5);
    check_irq(1'b1, "R6");
    reg_write(0, 32'h48);
    idle(1);
    check_irq(1'b0, "R6");

    // R8: zero coalescing
    reg_write(2, 32'h0);
    pulse_cause(32'h2);
    idle(1);
    check_irq(1'b0, "R8");
    idle(1);
    check_irq(1'b1, "R8");
    reg_write(0, 32'h2);
    idle(3);

    // R5: bypass with the widest window
    reg_write(2, 32'hff);
    pulse_hipri();
    idle(1);
    check_irq(1'b1, "R5");
    check_rd(0, 32'h8000_0000, "R5");
    reg_write(0, 32'h8000_0000);
    idle(3);
    check_irq(1'b0, "R5");

    // R5: bypass disabled by mask bit 31
    reg_write(1, 32'h7fff_ffff);
    pulse_hipri();
    idle(3);
    check_irq(1'b0, "R5");
    check_rd(0, 32'h8000_0000, "R5");
    reg_write(0, 32'h8000_0000);
    reg_write(1, 32'hffff_ffff);

    // R4: set and clear of bit 25 in the same cycle
    pulse_cause(32'h0200_0000);
    hw_cause = 32'h0200_0000;
    wr = 1'b1; addr = AW'(0); wdata = 32'h0200_0000;
    @(negedge clk);
    hw_cause = '0; wr = 1'b0; wdata = '0;
    check_rd(0, 32'h0200_0000, "R4");
    reg_write(0, 32'h0200_0000);
    check_rd(0, 32'h0, "R4");

    // R7: periodic generator, then disabled
    reg_write(1, 32'h0);
    reg_write(3, 32'h2);
    idle(4 * UNIT);
    check_rd(0, 32'h1000_0000, "R7");
    reg_write(3, 32'h0);
    reg_write(0, 32'h1000_0000);
    idle(10 * UNIT);
    check_rd(0, 32'h0, "R7");
    check_rd(3, 32'h0, "R7");

    // R7: periodic cause drives the line through a zero window
    reg_write(1, 32'h1000_0000);
    reg_write(2, 32'h0);
    reg_write(3, 32'h1);
    idle(3 * UNIT);
    check_irq(1'b1, "R7");
    reg_write(3, 32'h0);
    reg_write(0, 32'h1000_0000);
    idle(3);
    check_irq(1'b0, "R7");

    // R6: burst accumulates under one window
    reg_write(1, 32'hffff_ffff);
    reg_write(2, 32'h2);
    pulse_cause(32'h0000_0001);
    idle(1);
    pulse_cause(32'h0800_0000);
    idle(1);
    pulse_cause(32'h2000_0000);
    idle(3 * UNIT);
    check_irq(1'b1, "R6");
    check_rd(0, 32'h2800_0001, "R6");
    reg_write(0, 32'hffff_ffff);
    idle(2);
    check_irq(1'b0, "R6");

    // R3: a full-width window of 255 units
    reg_write(2, 32'hff);
    pulse_cause(32'h4);
    idle(250 * UNIT);
    check_irq(1'b0, "R3");
    idle(6 * UNIT + 4);
    check_irq(1'b1, "R3");
    reg_write(0, 32'h4);
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule